// File: doc/BRIEF.md
# Reloading 16-bit timer bank

The block holds four independent 16-bit down-counters behind a byte-wide register bus. Each counter steps down by one on every clock cycle where the tick-enable input is high. When a counter is at zero and another tick arrives, it takes a fresh value from its reload register and emits a one-cycle interrupt pulse. Software sets the reload value one byte at a time and then starts the counter with a start strobe.

The reload value is double-buffered. Writing new bytes without a start strobe leaves the current countdown alone and only changes what the next automatic reload loads. The live count is never read directly. A capture strobe freezes the count into a snapshot register, and the bus reads that snapshot.

Top module: `timer_bank`

## Requirements
- R1: The address selects the timer in addr[3:2] and the register in addr[1:0]. The register codes are 0 = reload low byte, 1 = reload high byte, 2 = start, 3 = capture. A read of code 0 returns bits 7:0 of that timer's snapshot and a read of code 1 returns bits 15:8. A read of code 2 or 3 returns 0. rdData is combinational from addr.
- R2: A write to the start register loads the 16-bit reload value, {high byte, low byte}, into the counter on that clock edge. The data byte of that write is ignored.
- R3: A counter decrements by one only on clock edges where tickEn is high. With tickEn low it holds its value.
- R4: On a tick edge where the count is 0, the counter reloads from its reload register and irqPulse[timer] is high for exactly the next cycle. A loaded value N therefore gives a pulse every N+1 ticks.
- R5: Writing the reload bytes without a start write does not change the countdown in progress. The new value is used at the next automatic reload.
- R6: A write to the capture register copies the current count into the snapshot. Reads return that frozen value until the next capture write for that timer.
- R7: The timers are independent. A write aimed at one timer changes no other timer's count, snapshot or interrupt.
- R8: After reset the reload values, counts and snapshots are all 0, and irqPulse is 0.
- R9: When a start write and an expiring tick fall on the same edge, the start write wins: the counter loads the reload value and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Count enable, one tick per high cycle |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Timer index and register code |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Snapshot byte selected by addr |
| irqPulse | output | 4 | One-cycle expiry pulse for each timer |

## Verification
A register write takes effect on the clock edge that samples it. A capture written on one edge can be read back right after that edge, because the read path is combinational. An interrupt pulse appears in the cycle after the tick edge on which the count stood at zero, so a value N first shows its pulse N+1 tick cycles after the start edge. The bench changes inputs and samples outputs on the falling edge. Each pulse is counted at the falling edge that follows the expiring rising edge. Each snapshot is read after a capture whose preceding tick count the bench knows exactly.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int NUM_TIMERS = 4;
  localparam int BYTE_W     = 8;
  localparam int CNT_W      = 2 * BYTE_W;
  localparam int IDX_W      = $clog2(NUM_TIMERS);
  localparam int FLD_W      = 2;
  localparam int ADDR_W     = IDX_W + FLD_W;

  typedef enum logic [FLD_W-1:0] {
    FLD_LO   = 2'd0,
    FLD_HI   = 2'd1,
    FLD_GO   = 2'd2,
    FLD_SNAP = 2'd3
  } field_e;

  typedef struct packed {
    logic [NUM_TIMERS-1:0] loWr;
    logic [NUM_TIMERS-1:0] hiWr;
    logic [NUM_TIMERS-1:0] goWr;
    logic [NUM_TIMERS-1:0] snapWr;
    logic [BYTE_W-1:0]     data;
    logic [IDX_W-1:0]      rdIdx;
    logic                  rdHi;
    logic                  rdValid;
  } ctrl_t;
endpackage

// File: rtl/timer_bank_ctrl.sv
module timer_bank_ctrl
  import timer_bank_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output ctrl_t             ctl
);
  logic [IDX_W-1:0] tmrIdx;
  field_e           fld;

  assign tmrIdx = addr[ADDR_W-1:FLD_W];
  assign fld    = field_e'(addr[FLD_W-1:0]);

  always_comb begin
    ctl         = '0;
    ctl.data    = wrData;
    ctl.rdIdx   = tmrIdx;
    ctl.rdHi    = (fld == FLD_HI);
    ctl.rdValid = (fld == FLD_LO) || (fld == FLD_HI);
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (wrEn && (tmrIdx == IDX_W'(i))) begin
        ctl.loWr[i]   = (fld == FLD_LO);
        ctl.hiWr[i]   = (fld == FLD_HI);
        ctl.goWr[i]   = (fld == FLD_GO);
        ctl.snapWr[i] = (fld == FLD_SNAP);
      end
    end
  end
endmodule

// File: rtl/timer_bank_dp.sv
module timer_bank_dp
  import timer_bank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  ctrl_t                 ctl,
  output logic [BYTE_W-1:0]     rdData,
  output logic [NUM_TIMERS-1:0] irqPulse
);
  logic [CNT_W-1:0] snapArr [NUM_TIMERS];

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : gChan
    logic [CNT_W-1:0] reloadQ;
    logic [CNT_W-1:0] countQ;
    logic [CNT_W-1:0] snapQ;
    logic             irqQ;
    logic             atZero;

    assign atZero = (countQ == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reloadQ <= '0;
        countQ  <= '0;
        snapQ   <= '0;
        irqQ    <= 1'b0;
      end else begin
        if (ctl.loWr[g]) reloadQ[BYTE_W-1:0]     <= ctl.data;
        if (ctl.hiWr[g]) reloadQ[CNT_W-1:BYTE_W] <= ctl.data;
        if (ctl.goWr[g]) begin
          countQ <= reloadQ;
        end else if (tickEn) begin
          if (atZero) countQ <= reloadQ;
          else        countQ <= countQ - 1'b1;
        end
        irqQ <= tickEn && atZero && !ctl.goWr[g];
        if (ctl.snapWr[g]) snapQ <= countQ;
      end
    end

    assign snapArr[g]  = snapQ;
    assign irqPulse[g] = irqQ;
  end

  logic [CNT_W-1:0] selSnap;
  assign selSnap = snapArr[ctl.rdIdx];

  always_comb begin
    if (!ctl.rdValid)  rdData = '0;
    else if (ctl.rdHi) rdData = selSnap[CNT_W-1:BYTE_W];
    else               rdData = selSnap[BYTE_W-1:0];
  end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BYTE_W-1:0]     wrData,
  output logic [BYTE_W-1:0]     rdData,
  output logic [NUM_TIMERS-1:0] irqPulse
);
  ctrl_t ctl;

  timer_bank_ctrl ctrl_i (
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .ctl    (ctl)
  );

  timer_bank_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .ctl      (ctl),
    .rdData   (rdData),
    .irqPulse (irqPulse)
  );
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk
  import timer_bank_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  tickEn,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     addr,
  input logic [BYTE_W-1:0]     wrData,
  input logic [BYTE_W-1:0]     rdData,
  input logic [NUM_TIMERS-1:0] irqPulse
);
  logic unusedData;
  assign unusedData = ^wrData;

  assert_irq_needs_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse != '0) |-> $past(tickEn));

  assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (irqPulse == '0));

  assert_ctrl_reads_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (addr[FLD_W-1:0] == FLD_GO || addr[FLD_W-1:0] == FLD_SNAP) |-> (rdData == '0));

  assert_snapshot_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn && addr[FLD_W-1:0] == FLD_SNAP) && addr == $past(addr))
      |-> (rdData == $past(rdData)));

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : gGo
    assert_go_beats_expiry_R9: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == {IDX_W'(g), FLD_GO}) |=> !irqPulse[g]);
  end
endmodule

bind timer_bank timer_bank_chk chk_i (.*);

// File: tb/timer_bank_tb_top.sv
module timer_bank_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [3:0] irqPulse;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  timer_bank dut_i (.*);

  typedef struct packed {
    logic [1:0]  tmr;
    logic [15:0] val;
    logic [7:0]  ticks;
    logic [15:0] expSnap;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd0, 16'h1234, 8'd0,  16'h1234},
    '{2'd1, 16'h00FF, 8'd5,  16'h00FA},
    '{2'd2, 16'hABCD, 8'd16, 16'hABBD},
    '{2'd3, 16'h0003, 8'd3,  16'h0000}
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int t, input int f, input int d);
    addr   = 4'((t << 2) | f);
    wrData = 8'(d);
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic rd16(input int t, output int v);
    int lo;
    addr = 4'(t << 2);
    #1 lo = int'(rdData);
    addr = 4'((t << 2) | 1);
    #1 v = (int'(rdData) << 8) | lo;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tickEn = 1'b1;
      repeat (n) @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic measure(input int idx, output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!irqPulse[idx] && cyc < 100);
  endtask

  task automatic load(input int t, input int v);
    wr(t, 0, v & 8'hFF);
    wr(t, 1, (v >> 8) & 8'hFF);
    wr(t, 2, 8'h5A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int v;
    int c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8: reset state
    check("R8 irq after reset", int'(irqPulse), 0);
    for (int t = 0; t < 4; t++) begin
      rd16(t, v);
      check("R8 snapshot after reset", v, 0);
    end

    // R1 R2 R3: vector table
    for (int i = 0; i < 4; i++) begin
      load(int'(VECS[i].tmr), int'(VECS[i].val));
      ticks(int'(VECS[i].ticks));
      wr(int'(VECS[i].tmr), 3, 0);
      rd16(int'(VECS[i].tmr), v);
      check("R2 R3 captured count", v, int'(VECS[i].expSnap));
      check("R3 no early irq", int'(irqPulse), 0);
      addr = 4'((int'(VECS[i].tmr) << 2) | 2);
      #1 check("R1 start reg reads zero", int'(rdData), 0);
      addr = 4'((int'(VECS[i].tmr) << 2) | 3);
      #1 check("R1 capture reg reads zero", int'(rdData), 0);
    end

    // R4 R7: timer 3 at zero, next tick reloads and pulses alone
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    check("R4 R7 expiry pulse", int'(irqPulse), 4'b1000);
    tickEn = 1'b1;
    measure(3, c);
    tickEn = 1'b0;
    check("R4 period N+1", c, 4);
    check("R7 only timer 3", int'(irqPulse), 4'b1000);
    @(negedge clk);
    check("R4 one-cycle pulse", int'(irqPulse[3]), 0);

    // R5: new reload bytes only affect the next reload
    load(1, 2);
    wr(1, 0, 5);
    tickEn = 1'b1;
    measure(1, c);
    check("R5 running period unchanged", c, 3);
    measure(1, c);
    tickEn = 1'b0;
    check("R5 next period uses new value", c, 6);

    // R6: snapshot frozen until next capture
    load(0, 16'h0010);
    wr(0, 3, 0);
    rd16(0, v);
    check("R6 capture", v, 16'h0010);
    ticks(4);
    rd16(0, v);
    check("R6 frozen without capture", v, 16'h0010);
    wr(0, 3, 0);
    rd16(0, v);
    check("R6 recapture", v, 16'h000C);

    // R9: start write on the expiring edge wins
    load(0, 0);
    wr(0, 0, 7);
    addr   = 4'b0010;
    wrData = 8'h00;
    wrEn   = 1'b1;
    tickEn = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
    tickEn = 1'b0;
    check("R9 no pulse when start wins", int'(irqPulse[0]), 0);
    wr(0, 3, 0);
    rd16(0, v);
    check("R9 reload value loaded", v, 7);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule